// File: doc/BRIEF.md
# Virtual Timer Countdown Access Decoder

This block decides what happens to a system-register access aimed at the countdown view of a virtual timer. The access arrives with one of two encodings. The hypervisor encoding names the hypervisor's own virtual timer. The guest encoding names the guest virtual timer, but host-mode settings can redirect it. The block also takes the current privilege level (0 to 3), a read/write flag and a set of configuration bits. From these it picks one outcome: an undefined-instruction exception, a trap to level 1, a trap to level 2, or an access to one of three timer register instances. The instances are the guest timer, the non-secure hypervisor timer and the secure hypervisor timer.

The decision is combinational. It is captured in a one-stage output register one cycle after a valid request. The stage is a two-state machine: `ST_IDLE` (no response presented) and `ST_RESP` (a response presented). There are three transitions. `IDLE->RESP` happens on a valid request. `RESP->RESP` happens on a back-to-back valid request. `RESP->IDLE` happens when no request arrives. The block does not perform the register access itself. The direction flag is carried along with the response so that whichever unit performs the access knows whether it is a read or a write.

Action codes on `rsp_action`: 0 undefined, 1 trap to level 1, 2 trap to level 2, 3 guest timer, 4 non-secure hypervisor timer, 5 secure hypervisor timer. On `req_hyp_enc`, 1 selects the hypervisor encoding and 0 selects the guest encoding.

Top module: `vtimer_trap_decode`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Reset drives `rsp_valid`, `rsp_action` and `rsp_ec` to 0.
- R2: For the hypervisor encoding (`req_hyp_enc`=1), `feat_present`=0 gives action 0 (undefined) at every level.
- R3: For the hypervisor encoding with the feature present, level 0 gives action 0. At level 1, `cfg_l2_en`=1 together with `cfg_nv`=1 gives action 2 (trap to level 2); any other setting gives action 0.
- R4: For the hypervisor encoding with the feature present, levels 2 and 3 give action 4 (non-secure hypervisor timer).
- R5: For the guest encoding at level 0, let host-user be `cfg_l2_en`&`cfg_host`&`cfg_tge`. When `cfg_k32`=0, host-user=0 and `cfg_k_uen`=0, the action is 2 if `cfg_l2_en`&`cfg_tge`, otherwise 1.
- R6: For the guest encoding at level 0, when R5 does not apply, host-user=1 and `cfg_h_uen`=0 give action 2.
- R7: For the guest encoding at level 0, when neither R5 nor R6 applies, host-user=1 gives action 4 if `cfg_ns`=1 and action 5 if `cfg_ns`=0. Every remaining case gives action 3 (guest timer).
- R8: For the guest encoding at levels 1 and 3, the action is always 3.
- R9: For the guest encoding at level 2, `cfg_host`=1 gives action 4 if `cfg_ns`=1 and action 5 otherwise. `cfg_host`=0 gives action 3.
- R10: `rsp_ec` is 0x18 when the action is 1 or 2, and 0 for every other action.
- R11: `req_write` has no effect on the action. It is returned unchanged on `rsp_write` with its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request present |
| req_el | input | 2 | Current privilege level |
| req_hyp_enc | input | 1 | 1 = hypervisor encoding, 0 = guest encoding |
| req_write | input | 1 | 1 = write, 0 = read |
| feat_present | input | 1 | Hypervisor timer view implemented |
| cfg_l2_en | input | 1 | Level 2 enabled |
| cfg_nv | input | 1 | Nested virtualization enable |
| cfg_host | input | 1 | Host mode |
| cfg_tge | input | 1 | Trap general exceptions |
| cfg_k_uen | input | 1 | User access enable set at kernel level |
| cfg_h_uen | input | 1 | User access enable set at hypervisor level |
| cfg_ns | input | 1 | 1 = non-secure state |
| cfg_k32 | input | 1 | Kernel level runs 32-bit |
| rsp_valid | output | 1 | Response present |
| rsp_action | output | 3 | Action code |
| rsp_ec | output | 6 | Exception class for traps |
| rsp_write | output | 1 | Direction of the decoded access |

## Verification
Two things can happen at the same clock edge: the block presents the response to one request and captures the next request, which keeps the machine in `ST_RESP`. The bench provokes this with long back-to-back streams that sweep every input combination. Short idle gaps force `RESP->IDLE` and `IDLE->RESP` between the streams. A scoreboard keeps requests in order, so a response that is shifted by one slot, or that appears during a gap, is reported as a mismatch or an unexpected response.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
    localparam int EL_W  = 2;
    localparam int ACT_W = 3;
    localparam int EC_W  = 6;
    localparam logic [EC_W-1:0] TRAP_EC = 6'h18;

    typedef enum logic [ACT_W-1:0] {
        ACT_UNDEF  = 3'd0,
        ACT_TRAP_K = 3'd1,
        ACT_TRAP_H = 3'd2,
        ACT_GUEST  = 3'd3,
        ACT_HYP_NS = 3'd4,
        ACT_HYP_S  = 3'd5
    } vtd_act_e;

    typedef struct packed {
        logic l2_en;
        logic nv;
        logic host;
        logic tge;
        logic k_uen;
        logic h_uen;
        logic ns;
        logic k32;
    } vtd_cfg_t;
endpackage

// File: rtl/vtd_hyp_dec.sv
module vtd_hyp_dec
    import vtd_pkg::*;
(
    input  logic [EL_W-1:0] el,
    input  logic            feat,
    input  vtd_cfg_t        cfg,
    output vtd_act_e        act
);
    always_comb begin
        act = ACT_UNDEF;
        if (feat) begin
            unique case (el)
                2'd0: act = ACT_UNDEF;
                2'd1: act = (cfg.l2_en && cfg.nv) ? ACT_TRAP_H : ACT_UNDEF;
                default: act = ACT_HYP_NS;
            endcase
        end
    end
endmodule

// File: rtl/vtd_guest_dec.sv
module vtd_guest_dec
    import vtd_pkg::*;
(
    input  logic [EL_W-1:0] el,
    input  vtd_cfg_t        cfg,
    output vtd_act_e        act
);
    logic     host_user;
    vtd_act_e hyp_pick;

    assign host_user = cfg.l2_en & cfg.host & cfg.tge;
    assign hyp_pick  = cfg.ns ? ACT_HYP_NS : ACT_HYP_S;

    always_comb begin
        act = ACT_GUEST;
        unique case (el)
            2'd0: begin
                if (!cfg.k32 && !host_user && !cfg.k_uen)
                    act = (cfg.l2_en && cfg.tge) ? ACT_TRAP_H : ACT_TRAP_K;
                else if (host_user && !cfg.h_uen)
                    act = ACT_TRAP_H;
                else if (host_user)
                    act = hyp_pick;
                else
                    act = ACT_GUEST;
            end
            2'd2:    act = cfg.host ? hyp_pick : ACT_GUEST;
            default: act = ACT_GUEST;
        endcase
    end
endmodule

// File: rtl/vtimer_trap_decode.sv
module vtimer_trap_decode
    import vtd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [EL_W-1:0]  req_el,
    input  logic             req_hyp_enc,
    input  logic             req_write,
    input  logic             feat_present,
    input  logic             cfg_l2_en,
    input  logic             cfg_nv,
    input  logic             cfg_host,
    input  logic             cfg_tge,
    input  logic             cfg_k_uen,
    input  logic             cfg_h_uen,
    input  logic             cfg_ns,
    input  logic             cfg_k32,
    output logic             rsp_valid,
    output logic [ACT_W-1:0] rsp_action,
    output logic [EC_W-1:0]  rsp_ec,
    output logic             rsp_write
);
    typedef enum logic {ST_IDLE, ST_RESP} st_e;

    st_e      state, state_nx;
    vtd_cfg_t cfg;
    vtd_act_e hyp_act, guest_act, sel_act;
    logic     sel_trap;

    assign cfg = '{l2_en: cfg_l2_en, nv: cfg_nv, host: cfg_host, tge: cfg_tge,
                   k_uen: cfg_k_uen, h_uen: cfg_h_uen, ns: cfg_ns, k32: cfg_k32};

    vtd_hyp_dec u_hyp (
        .el   (req_el),
        .feat (feat_present),
        .cfg  (cfg),
        .act  (hyp_act)
    );

    vtd_guest_dec u_guest (
        .el  (req_el),
        .cfg (cfg),
        .act (guest_act)
    );

    assign sel_act  = req_hyp_enc ? hyp_act : guest_act;
    assign sel_trap = (sel_act == ACT_TRAP_K) || (sel_act == ACT_TRAP_H);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid)  state_nx = ST_RESP;
            ST_RESP: if (!req_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_action <= '0;
            rsp_ec     <= '0;
            rsp_write  <= 1'b0;
        end else if (req_valid) begin
            rsp_action <= sel_act;
            rsp_ec     <= sel_trap ? TRAP_EC : '0;
            rsp_write  <= req_write;
        end
    end

    assign rsp_valid = (state == ST_RESP);
endmodule

// File: rtl/vtd_checker.sv
module vtd_checker
    import vtd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [EL_W-1:0]  req_el,
    input logic             req_hyp_enc,
    input logic             req_write,
    input logic             feat_present,
    input logic             cfg_host,
    input logic             cfg_ns,
    input logic             rsp_valid,
    input logic [ACT_W-1:0] rsp_action,
    input logic [EC_W-1:0]  rsp_ec,
    input logic             rsp_write
);
    a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_no_feature: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hyp_enc && !feat_present) |=> (rsp_action == 3'd0));
    a_r4_hyp_high: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hyp_enc && feat_present && req_el[1]) |=> (rsp_action == 3'd4));
    a_r8_guest_l13: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hyp_enc && req_el[0]) |=> (rsp_action == 3'd3));
    a_r9_guest_l2_host: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_hyp_enc && req_el == 2'd2 && cfg_host)
            |=> (rsp_action == (cfg_ns_q ? 3'd4 : 3'd5)));
    a_r10_ec_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_action == 3'd1 || rsp_action == 3'd2)) |-> (rsp_ec == 6'h18));
    a_r10_ec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !(rsp_action == 3'd1 || rsp_action == 3'd2)) |-> (rsp_ec == 6'h00));
    a_r11_write_echo: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_write == cfg_wr_q));

    logic cfg_ns_q, cfg_wr_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_ns_q <= 1'b0;
            cfg_wr_q <= 1'b0;
        end else begin
            cfg_ns_q <= cfg_ns;
            cfg_wr_q <= req_write;
        end
    end
endmodule

bind vtimer_trap_decode vtd_checker u_chk (.*);

// File: tb/sim_vtimer_trap_decode.sv
`timescale 1ns/1ps
module sim_vtimer_trap_decode;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_hyp_enc = 1'b0, req_write = 1'b0, feat_present = 1'b0;
    logic [1:0] req_el = 2'd0;
    logic cfg_l2_en = 0, cfg_nv = 0, cfg_host = 0, cfg_tge = 0;
    logic cfg_k_uen = 0, cfg_h_uen = 0, cfg_ns = 0, cfg_k32 = 0;
    logic       rsp_valid, rsp_write;
    logic [2:0] rsp_action;
    logic [5:0] rsp_ec;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    vtimer_trap_decode u0 (.*);

    // Expected outcome taken from the requirements; tag names the rule used.
    function automatic void model(input logic [12:0] v, output logic [2:0] act, output string tag);
        logic [1:0] el;
        logic hyp, feat, l2, nv, host, tge, ku, hu, ns, k32, hu_ok;
        {el, hyp, feat, l2, nv, host, tge, ku, hu, ns, k32} = {v[12:11], v[10], v[9],
            v[8], v[7], v[6], v[5], v[4], v[3], v[2], v[1]};
        hu_ok = l2 & host & tge;
        if (hyp) begin
            if (!feat) begin act = 3'd0; tag = "R2"; end
            else if (el == 2'd0) begin act = 3'd0; tag = "R3"; end
            else if (el == 2'd1) begin act = (l2 && nv) ? 3'd2 : 3'd0; tag = "R3"; end
            else begin act = 3'd4; tag = "R4"; end
        end else if (el == 2'd0) begin
            if (!k32 && !hu_ok && !ku) begin act = (l2 && tge) ? 3'd2 : 3'd1; tag = "R5"; end
            else if (hu_ok && !hu) begin act = 3'd2; tag = "R6"; end
            else if (hu_ok) begin act = ns ? 3'd4 : 3'd5; tag = "R7"; end
            else begin act = 3'd3; tag = "R7"; end
        end else if (el == 2'd2) begin
            act = host ? (ns ? 3'd4 : 3'd5) : 3'd3; tag = "R9";
        end else begin
            act = 3'd3; tag = "R8";
        end
    endfunction

    // Bit 0 of v is the write flag.
    task automatic drive(input logic [12:0] v);
        logic [2:0] a;
        string t;
        @(negedge clk);
        req_valid = 1'b1;
        {req_el, req_hyp_enc, feat_present, cfg_l2_en, cfg_nv, cfg_host, cfg_tge,
         cfg_k_uen, cfg_h_uen, cfg_ns, cfg_k32, req_write} = v;
        model(v, a, t);
        exp_q.push_back({v[0], a});
        tag_q.push_back(t);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected response", 1, 0);
            end else begin
                logic [3:0] e;
                string t;
                logic [5:0] eec;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                eec = (e[2:0] == 3'd1 || e[2:0] == 3'd2) ? 6'h18 : 6'h00;
                chk(rsp_action == e[2:0], t, rsp_action, e[2:0]);
                chk(rsp_ec == eec, "R10", rsp_ec, eec);
                chk(rsp_write == e[3], "R11", rsp_write, e[3]);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rsp_valid == 0 && rsp_action == 0 && rsp_ec == 0, "R1 reset",
            {rsp_valid, rsp_action, rsp_ec}, 0);
        rst_n = 1'b1;
        // Directed corners: {el,hyp,feat,l2,nv,host,tge,ku,hu,ns,k32,wr}
        drive(13'b01_1_1_1_1_0000_00_0); // R3 trap to level 2
        drive(13'b01_1_0_1_1_0000_00_0); // R2 no feature
        drive(13'b00_0_1_1_0_0100_00_1); // R5 trap to level 2, write
        drive(13'b00_0_1_0_0_0000_00_0); // R5 trap to level 1
        drive(13'b00_0_1_1_0_1110_00_0); // R6
        drive(13'b00_0_1_1_0_1111_00_0); // R7 secure
        drive(13'b00_0_1_1_0_1111_10_0); // R7 non-secure
        drive(13'b10_0_1_1_0_1000_00_0); // R9 secure
        drive(13'b11_0_1_1_0_1111_10_1); // R8
        idle();
        idle();
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 idle gap", rsp_valid, 0);
        // Exhaustive sweep with periodic gaps
        for (int i = 0; i < 8192; i++) begin
            drive(i[12:0]);
            if (i % 97 == 96) begin idle(); idle(); end
        end
        idle();
        idle();
        idle();
        chk(exp_q.size() == 0, "R1 missing responses", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule